// File: doc/BRIEF.md
# Backplane Bus Slave with Burst Addressing

This block answers transfers on an 8-bit asynchronous backplane as a slave. It samples the active-low address and data strobes through two-flop synchronizers, decodes the three-bit command code together with the bus address, and decides whether it is the target. There are three ways it can be selected: a memory window, an I/O window, or a vector fetch for the attention level it is currently raising. Once selected, it reads or writes a byte through a plain local port. On reads it drives the data lines, and it reports success with an acknowledge or failure with a transfer error.

An internal offset counter lets one address phase serve a burst. The master keeps the address strobe asserted and the bus address unchanged while it pulses the data strobe for each byte. The first handshake uses the offset taken from the bus address. Each later handshake moves the offset by one, upward by default or downward when a parameter selects it. If an access falls inside the window but is not allowed locally, the block raises the error line and does not acknowledge. Two cases count as not allowed: a write to the read-only upper part of the memory window, and a burst that runs past the window's edge.

The bus strobes and the acknowledge/error outputs are expressed as levels. External open-collector drivers and inverters are outside this block.

Top module: `bus_slave_burst`

## Requirements
- R1: After reset, xferAck, xferErr, busDataOe and locWe are all low.
- R2: A data strobe asserted while the address strobe is released produces no acknowledge, no error and no data drive.
- R3: Command codes 000, 001 and 010 are ignored completely: no acknowledge, no error, no data drive, and no local write.
- R4: A read of the memory window (command 111) turns busDataOe on at least SETUP_CYC clock cycles before xferAck rises, and the byte on busDataOut is the local byte at the offset (bus address minus MEM_BASE).
- R5: A write (memory 110, I/O 100) pulses locWe once with the captured byte. xferAck rises in the following cycle, and busDataOe stays low throughout.
- R6: Releasing either strobe makes xferAck, xferErr and busDataOe go low within four clock cycles.
- R7: During a burst the offset used by the k-th handshake (k counted from 0) is the first offset plus k. The bus address is held constant throughout.
- R8: With BURST_DOWN=1 the k-th handshake uses the first offset minus k.
- R9: xferAck and xferErr are never high together.
- R10: A memory write at an offset of RO_OFFSET or above raises xferErr rather than xferAck and leaves the stored byte unchanged.
- R11: A burst handshake whose offset leaves the window raises xferErr rather than xferAck.
- R12: A vector fetch (command 011) is answered with vectorByte only when attnActive is high and bus address bits [2:0] equal attnLevel. Otherwise it is ignored.
- R13: I/O commands (101 read, 100 write) decode bus address bits [IO_W-1:0] against the window IO_BASE to IO_BASE+IO_SIZE-1 and set locSpaceIo high.
- R14: A memory or I/O address outside its window gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrStbN | input | 1 | Address strobe, active low, asynchronous |
| dataStbN | input | 1 | Data strobe, active low, asynchronous |
| cmdCode | input | 3 | Transfer command code |
| busAddr | input | ADDR_W | Bus address |
| busDataIn | input | 8 | Bus data seen by the slave |
| busDataOut | output | 8 | Read data for the bus |
| busDataOe | output | 1 | Enable for the bus data drivers |
| xferAck | output | 1 | Transfer acknowledge (high = asserted) |
| xferErr | output | 1 | Transfer error (high = asserted) |
| attnLevel | input | 3 | Attention level this board raises |
| attnActive | input | 1 | The attention request is currently raised |
| vectorByte | input | 8 | Byte returned on a matching vector fetch |
| locAddr | output | LOC_W | Local offset |
| locSpaceIo | output | 1 | High when the local access targets I/O space |
| locWe | output | 1 | Local write strobe, one cycle |
| locWdata | output | 8 | Local write byte |
| locRdata | input | 8 | Local read byte for locAddr and locSpaceIo |

## Verification
The bench builds two copies of the block with the default windows: memory at 0x04000 with 64 bytes, of which offsets 48 and up are read-only, and I/O at 0x100 with 16 locations, with SETUP_CYC of 2. The first copy counts bursts upward. The second sets BURST_DOWN to 1 so that the descending counter can be observed. Because the windows are small, a short burst starting near offset 62 runs past the top of the window, and a single write at offset 48 reaches the read-only region. A setup of two cycles leaves a visible gap between the data enable and the acknowledge.

// File: rtl/bslv_pkg.sv
package bslv_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic takeOff;  // accept a handshake: latch offset, space, write byte
    logic wrEn;     // issue the local write
    logic rdCap;    // capture the local read byte into the output register
  } dpCtlT;

  // Decode result from the datapath to the control FSM
  typedef struct packed {
    logic hit;      // this slave is the target
    logic isRead;   // the transfer returns data
    logic illegal;  // targeted but not allowed locally
  } decodeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WRITE, ST_ACK, ST_ERR, ST_IGNORE
  } stateT;

  localparam logic [2:0] CMD_VEC   = 3'b011;
  localparam logic [2:0] CMD_IOWR  = 3'b100;
  localparam logic [2:0] CMD_IORD  = 3'b101;
  localparam logic [2:0] CMD_MEMWR = 3'b110;
  localparam logic [2:0] CMD_MEMRD = 3'b111;

endpackage

// File: rtl/bslv_sync.sv
module bslv_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/bslv_ctrl.sv
module bslv_ctrl
  import bslv_pkg::*;
#(
  parameter int SETUP_CYC = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   asAct,
  input  logic   dsAct,
  input  decodeT dec,
  output dpCtlT  dpCtl,
  output logic   oe,
  output logic   ack,
  output logic   err
);

  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);

  stateT         state, nextState;
  logic [CW-1:0] setupCnt;
  logic          dsPrev;
  logic          rdTxn;
  logic          dsRise;
  logic          released;
  logic          accept;

  assign dsRise   = dsAct & ~dsPrev;
  assign released = !asAct || !dsAct;
  assign accept   = (state == ST_IDLE) && asAct && dsRise;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!dec.hit)          nextState = ST_IGNORE;
          else if (dec.illegal)  nextState = ST_ERR;
          else if (dec.isRead)   nextState = ST_SETUP;
          else                   nextState = ST_WRITE;
        end
      end
      ST_SETUP: begin
        if (released)                    nextState = ST_IDLE;
        else if (setupCnt == SETUP_LAST) nextState = ST_ACK;
      end
      ST_WRITE:  nextState = ST_ACK;
      ST_ACK, ST_ERR, ST_IGNORE: begin
        if (released) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      setupCnt <= '0;
      dsPrev   <= 1'b0;
      rdTxn    <= 1'b0;
    end else begin
      state  <= nextState;
      dsPrev <= dsAct;
      if (state == ST_SETUP) setupCnt <= setupCnt + 1'b1;
      else                   setupCnt <= '0;
      if (accept) rdTxn <= dec.isRead;
    end
  end

  always_comb begin
    dpCtl.takeOff = accept;
    dpCtl.wrEn    = (state == ST_WRITE);
    dpCtl.rdCap   = (state == ST_SETUP);
  end

  assign oe  = (state == ST_SETUP) || ((state == ST_ACK) && rdTxn);
  assign ack = (state == ST_ACK);
  assign err = (state == ST_ERR);

endmodule

// File: rtl/bslv_datapath.sv
module bslv_datapath
  import bslv_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int MEM_BASE   = 'h04000,
  parameter int MEM_SIZE   = 64,
  parameter int RO_OFFSET  = 48,
  parameter int IO_W       = 12,
  parameter int IO_BASE    = 'h100,
  parameter int IO_SIZE    = 16,
  parameter int BURST_DOWN = 0,
  parameter int LOC_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asAct,
  input  logic [2:0]        cmdCode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busDataIn,
  input  logic [2:0]        attnLevel,
  input  logic              attnActive,
  input  logic [7:0]        vectorByte,
  input  dpCtlT             dpCtl,
  output decodeT            dec,
  output logic [LOC_W-1:0]  locAddr,
  output logic              locSpaceIo,
  output logic              locWe,
  output logic [7:0]        locWdata,
  input  logic [7:0]        locRdata,
  output logic [7:0]        busDataOut
);

  // Two spare bits so a burst that leaves the window stays out of it
  localparam int PTR_W = LOC_W + 2;
  localparam logic [ADDR_W:0]  MEM_LO  = (ADDR_W+1)'(MEM_BASE);
  localparam logic [ADDR_W:0]  MEM_HI  = (ADDR_W+1)'(MEM_BASE + MEM_SIZE);
  localparam logic [IO_W:0]    IO_LO   = (IO_W+1)'(IO_BASE);
  localparam logic [IO_W:0]    IO_HI   = (IO_W+1)'(IO_BASE + IO_SIZE);
  localparam logic [PTR_W-1:0] MEM_LIM = PTR_W'(MEM_SIZE);
  localparam logic [PTR_W-1:0] IO_LIM  = PTR_W'(IO_SIZE);
  localparam logic [PTR_W-1:0] RO_LIM  = PTR_W'(RO_OFFSET);

  logic             isMemCmd, isIoCmd, isRdCmd, isVecCmd;
  logic             memHit, ioHit, vecMatch;
  logic [IO_W:0]    ioField;
  logic [PTR_W-1:0] memFirst, ioFirst, firstOff, stepOff, effOff, limit;
  logic [PTR_W-1:0] curOff;
  logic             firstDone;
  logic             spaceIo, vecTxn;
  logic [7:0]       wdataQ, rdQ;

  // Command classification
  assign isMemCmd = cmdCode[2] &  cmdCode[1];
  assign isIoCmd  = cmdCode[2] & ~cmdCode[1];
  assign isRdCmd  = cmdCode[0];
  assign isVecCmd = (cmdCode == CMD_VEC);

  // Window decode on the (stable) bus address
  assign ioField = {1'b0, busAddr[IO_W-1:0]};
  assign memHit  = ({1'b0, busAddr} >= MEM_LO) && ({1'b0, busAddr} < MEM_HI);
  assign ioHit   = (ioField >= IO_LO) && (ioField < IO_HI);
  assign memFirst = PTR_W'({1'b0, busAddr} - MEM_LO);
  assign ioFirst  = PTR_W'(ioField - IO_LO);
  assign vecMatch = isVecCmd && attnActive && (busAddr[2:0] == attnLevel);

  // Burst step direction picked by parameter
  generate
    if (BURST_DOWN != 0) begin : g_down
      assign stepOff = curOff - 1'b1;
    end else begin : g_up
      assign stepOff = curOff + 1'b1;
    end
  endgenerate

  assign firstOff = isIoCmd ? ioFirst : memFirst;
  assign effOff   = firstDone ? stepOff : firstOff;
  assign limit    = isIoCmd ? IO_LIM : MEM_LIM;

  always_comb begin
    dec.hit     = (isMemCmd && memHit) || (isIoCmd && ioHit) || vecMatch;
    dec.isRead  = isRdCmd || vecMatch;
    dec.illegal = !isVecCmd &&
                  ((effOff >= limit) || (isMemCmd && !isRdCmd && (effOff >= RO_LIM)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOff    <= '0;
      firstDone <= 1'b0;
      spaceIo   <= 1'b0;
      vecTxn    <= 1'b0;
      wdataQ    <= '0;
      rdQ       <= '0;
    end else begin
      if (!asAct) begin
        firstDone <= 1'b0;
      end else if (dpCtl.takeOff) begin
        firstDone <= 1'b1;
        curOff    <= effOff;
        spaceIo   <= isIoCmd;
        vecTxn    <= vecMatch;
        wdataQ    <= busDataIn;
      end
      if (dpCtl.rdCap) rdQ <= vecTxn ? vectorByte : locRdata;
    end
  end

  assign locAddr    = curOff[LOC_W-1:0];
  assign locSpaceIo = spaceIo;
  assign locWe      = dpCtl.wrEn;
  assign locWdata   = wdataQ;
  assign busDataOut = rdQ;

endmodule

// File: rtl/bus_slave_burst.sv
module bus_slave_burst
  import bslv_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int MEM_BASE   = 'h04000,
  parameter int MEM_SIZE   = 64,
  parameter int RO_OFFSET  = 48,
  parameter int IO_W       = 12,
  parameter int IO_BASE    = 'h100,
  parameter int IO_SIZE    = 16,
  parameter int SETUP_CYC  = 2,
  parameter int BURST_DOWN = 0,
  localparam int LOC_W = $clog2((MEM_SIZE > IO_SIZE) ? MEM_SIZE : IO_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStbN,
  input  logic              dataStbN,
  input  logic [2:0]        cmdCode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busDataIn,
  output logic [7:0]        busDataOut,
  output logic              busDataOe,
  output logic              xferAck,
  output logic              xferErr,
  input  logic [2:0]        attnLevel,
  input  logic              attnActive,
  input  logic [7:0]        vectorByte,
  output logic [LOC_W-1:0]  locAddr,
  output logic              locSpaceIo,
  output logic              locWe,
  output logic [7:0]        locWdata,
  input  logic [7:0]        locRdata
);

  logic [1:0] stbSync;
  logic       asAct, dsAct;
  dpCtlT      dpCtl;
  decodeT     dec;

  bslv_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({~addrStbN, ~dataStbN}),
    .syncOut(stbSync)
  );

  assign asAct = stbSync[1];
  assign dsAct = stbSync[0];

  bslv_ctrl #(.SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .asAct(asAct),
    .dsAct(dsAct),
    .dec  (dec),
    .dpCtl(dpCtl),
    .oe   (busDataOe),
    .ack  (xferAck),
    .err  (xferErr)
  );

  bslv_datapath #(
    .ADDR_W    (ADDR_W),
    .MEM_BASE  (MEM_BASE),
    .MEM_SIZE  (MEM_SIZE),
    .RO_OFFSET (RO_OFFSET),
    .IO_W      (IO_W),
    .IO_BASE   (IO_BASE),
    .IO_SIZE   (IO_SIZE),
    .BURST_DOWN(BURST_DOWN),
    .LOC_W     (LOC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .asAct     (asAct),
    .cmdCode   (cmdCode),
    .busAddr   (busAddr),
    .busDataIn (busDataIn),
    .attnLevel (attnLevel),
    .attnActive(attnActive),
    .vectorByte(vectorByte),
    .dpCtl     (dpCtl),
    .dec       (dec),
    .locAddr   (locAddr),
    .locSpaceIo(locSpaceIo),
    .locWe     (locWe),
    .locWdata  (locWdata),
    .locRdata  (locRdata),
    .busDataOut(busDataOut)
  );

endmodule

// File: rtl/bslv_check.sv
module bslv_check (
  input logic       clk,
  input logic       rstN,
  input logic       xferAck,
  input logic       xferErr,
  input logic       busDataOe,
  input logic       locWe,
  input logic [2:0] cmdCode
);

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(xferAck && xferErr)); // R9

  AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    locWe |=> xferAck); // R5

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    locWe |-> !busDataOe); // R5

  AST_READ_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferAck) && busDataOe) |-> $past(busDataOe)); // R4

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (xferAck || xferErr || busDataOe || locWe) |-> (cmdCode[2] || cmdCode == 3'b011)); // R3

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferErr) |-> !$past(locWe)); // R10

endmodule

bind bus_slave_burst bslv_check u_check (
  .clk      (clk),
  .rstN     (rstN),
  .xferAck  (xferAck),
  .xferErr  (xferErr),
  .busDataOe(busDataOe),
  .locWe    (locWe),
  .cmdCode  (cmdCode)
);

// File: tb/bus_slave_burst_test.sv
module bus_slave_burst_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        asN = 1'b1, dsN = 1'b1, useDn = 1'b0;
  logic [2:0]  cmd = 3'b111;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  attnLvl = 3'd5;
  logic        attnOn = 1'b0;
  logic [7:0]  vecByte = 8'h9E;

  logic [7:0] mOut, dOut, mLocWdata, dLocWdata, mLocRdata, dLocRdata;
  logic       mOe, mAck, mErr, dOe, dAck, dErr;
  logic [5:0] mLocAddr, dLocAddr;
  logic       mSpaceIo, dSpaceIo, mLocWe, dLocWe;

  logic [7:0] memArr [64];
  logic [7:0] ioArr  [16];

  bus_slave_burst uut (
    .clk(clk), .rstN(rstN), .addrStbN(asN | useDn), .dataStbN(dsN | useDn),
    .cmdCode(cmd), .busAddr(addr), .busDataIn(wdata), .busDataOut(mOut),
    .busDataOe(mOe), .xferAck(mAck), .xferErr(mErr), .attnLevel(attnLvl),
    .attnActive(attnOn), .vectorByte(vecByte), .locAddr(mLocAddr),
    .locSpaceIo(mSpaceIo), .locWe(mLocWe), .locWdata(mLocWdata), .locRdata(mLocRdata));

  bus_slave_burst #(.BURST_DOWN(1)) uutDown (
    .clk(clk), .rstN(rstN), .addrStbN(asN | ~useDn), .dataStbN(dsN | ~useDn),
    .cmdCode(cmd), .busAddr(addr), .busDataIn(wdata), .busDataOut(dOut),
    .busDataOe(dOe), .xferAck(dAck), .xferErr(dErr), .attnLevel(attnLvl),
    .attnActive(attnOn), .vectorByte(vecByte), .locAddr(dLocAddr),
    .locSpaceIo(dSpaceIo), .locWe(dLocWe), .locWdata(dLocWdata), .locRdata(dLocRdata));

  // Local storage models
  assign mLocRdata = mSpaceIo ? ioArr[mLocAddr[3:0]] : memArr[mLocAddr];
  assign dLocRdata = {2'b10, dLocAddr};

  always @(posedge clk) begin
    if (mLocWe) begin
      if (mSpaceIo) ioArr[mLocAddr[3:0]] <= mLocWdata;
      else          memArr[mLocAddr]     <= mLocWdata;
    end
  end

  logic [7:0] curOut;
  logic       curOe, curAck, curErr;
  assign curOut = useDn ? dOut : mOut;
  assign curOe  = useDn ? dOe  : mOe;
  assign curAck = useDn ? dAck : mAck;
  assign curErr = useDn ? dErr : mErr;

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] initMem(input int i);
    return 8'(i * 3 + 7);
  endfunction

  task automatic openAddr(input logic [2:0] c, input logic [19:0] a);
    @(negedge clk);
    cmd = c; addr = a; asN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic closeAddr();
    @(negedge clk);
    asN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One data-strobe handshake; checks release timing (R6) and exclusivity (R9)
  task automatic handshake(input logic [7:0] wd, output logic gotAck, output logic gotErr,
                           output logic [7:0] rd, output int oeCnt);
    int rel;
    wdata = wd; dsN = 1'b0; oeCnt = 0; gotAck = 1'b0; gotErr = 1'b0; rd = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (curAck || curErr) begin
        gotAck = curAck; gotErr = curErr; rd = curOut;
        break;
      end
      if (curOe) oeCnt++;
    end
    chk("R9", "ack and err together", int'(curAck && curErr), 0);
    dsN = 1'b1;
    rel = 0;
    for (int i = 0; i < 8; i++) begin
      if (!(curAck || curErr || curOe)) break;
      @(negedge clk);
      rel++;
    end
    if (gotAck || gotErr) chk("R6", "cycles to release after data strobe", int'(rel <= 4), 1);
    @(negedge clk);
  endtask

  task automatic singleRead(input logic [2:0] c, input logic [19:0] a, output logic gAck,
                            output logic gErr, output logic [7:0] rd, output int oeCnt);
    openAddr(c, a);
    handshake(8'h00, gAck, gErr, rd, oeCnt);
    closeAddr();
  endtask

  task automatic singleWrite(input logic [2:0] c, input logic [19:0] a, input logic [7:0] wd,
                             output logic gAck, output logic gErr);
    logic [7:0] rd; int oc;
    openAddr(c, a);
    handshake(wd, gAck, gErr, rd, oc);
    closeAddr();
  endtask

  task automatic testReset();
    chk("R1", "ack after reset", int'(mAck), 0);
    chk("R1", "err after reset", int'(mErr), 0);
    chk("R1", "oe after reset",  int'(mOe),  0);
    chk("R1", "locWe after reset", int'(mLocWe), 0);
  endtask

  task automatic testMemRead();
    logic a, e; logic [7:0] rd; int oc;
    singleRead(3'b111, 20'h04005, a, e, rd, oc);
    chk("R4", "read ack", int'(a), 1);
    chk("R4", "read data offset 5", int'(rd), int'(initMem(5)));
    chk("R4", "oe cycles before ack >= 2", int'(oc >= 2), 1);
  endtask

  task automatic testMemWrite();
    logic a, e; logic [7:0] rd; int oc;
    singleWrite(3'b110, 20'h04003, 8'h5C, a, e);
    chk("R5", "write ack", int'(a), 1);
    chk("R5", "write err", int'(e), 0);
    singleRead(3'b111, 20'h04003, a, e, rd, oc);
    chk("R5", "read back written byte", int'(rd), 8'h5C);
  endtask

  task automatic testDsWithoutAs();
    int seen = 0;
    @(negedge clk);
    cmd = 3'b111; addr = 20'h04001; dsN = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mAck || mErr || mOe) seen++;
    end
    dsN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", "response to data strobe without address strobe", seen, 0);
  endtask

  task automatic testReserved();
    logic a, e; logic [7:0] rd; int oc;
    for (int c = 0; c < 3; c++) begin
      singleWrite(3'(c), 20'h04007, 8'hEE, a, e);
      chk("R3", "reserved code ack/err", int'(a || e), 0);
    end
    singleRead(3'b111, 20'h04007, a, e, rd, oc);
    chk("R3", "byte untouched after reserved codes", int'(rd), int'(initMem(7)));
  endtask

  task automatic testOutside();
    logic a, e; logic [7:0] rd; int oc;
    singleRead(3'b111, 20'h04040, a, e, rd, oc);
    chk("R14", "above memory window", int'(a || e || oc != 0), 0);
    singleRead(3'b111, 20'h03FFF, a, e, rd, oc);
    chk("R14", "below memory window", int'(a || e || oc != 0), 0);
  endtask

  task automatic testBurstUp();
    logic a, e; logic [7:0] rd; int oc;
    openAddr(3'b111, 20'h04008);
    for (int k = 0; k < 4; k++) begin
      handshake(8'h00, a, e, rd, oc);
      chk("R7", $sformatf("burst read k=%0d", k), int'(rd), int'(initMem(8 + k)));
    end
    closeAddr();
    openAddr(3'b110, 20'h04010);
    for (int k = 0; k < 3; k++) begin
      handshake(8'h30 + 8'(k), a, e, rd, oc);
      chk("R7", "burst write ack", int'(a), 1);
    end
    closeAddr();
    for (int k = 0; k < 3; k++) begin
      singleRead(3'b111, 20'h04010 + 20'(k), a, e, rd, oc);
      chk("R7", $sformatf("burst write landed k=%0d", k), int'(rd), 8'h30 + k);
    end
  endtask

  task automatic testReadOnly();
    logic a, e; logic [7:0] rd; int oc;
    singleWrite(3'b110, 20'h04030, 8'h11, a, e);
    chk("R10", "read-only write err", int'(e), 1);
    chk("R10", "read-only write ack", int'(a), 0);
    singleRead(3'b111, 20'h04030, a, e, rd, oc);
    chk("R10", "read-only byte unchanged", int'(rd), int'(initMem(48)));
  endtask

  task automatic testBurstEdge();
    logic a, e; logic [7:0] rd; int oc;
    openAddr(3'b111, 20'h0403E);
    handshake(8'h00, a, e, rd, oc);
    chk("R11", "offset 62 ok", int'(a), 1);
    handshake(8'h00, a, e, rd, oc);
    chk("R11", "offset 63 ok", int'(a), 1);
    handshake(8'h00, a, e, rd, oc);
    chk("R11", "offset 64 err", int'(e), 1);
    chk("R11", "offset 64 no ack", int'(a), 0);
    closeAddr();
  endtask

  task automatic testIo();
    logic a, e; logic [7:0] rd; int oc;
    singleRead(3'b101, 20'h00105, a, e, rd, oc);
    chk("R13", "io read data", int'(rd), 8'hA5);
    singleWrite(3'b100, 20'h0010F, 8'h33, a, e);
    chk("R13", "io write ack", int'(a), 1);
    singleRead(3'b101, 20'h0010F, a, e, rd, oc);
    chk("R13", "io read back", int'(rd), 8'h33);
    chk("R13", "memory untouched by io write", int'(memArr[15]), int'(initMem(15)));
    singleRead(3'b101, 20'h00110, a, e, rd, oc);
    chk("R13", "io outside window silent", int'(a || e), 0);
  endtask

  task automatic testVector();
    logic a, e; logic [7:0] rd; int oc;
    attnOn = 1'b1; attnLvl = 3'd5;
    singleRead(3'b011, 20'h00005, a, e, rd, oc);
    chk("R12", "vector match ack", int'(a), 1);
    chk("R12", "vector byte", int'(rd), 8'h9E);
    singleRead(3'b011, 20'h00004, a, e, rd, oc);
    chk("R12", "vector other level silent", int'(a || e), 0);
    attnOn = 1'b0;
    singleRead(3'b011, 20'h00005, a, e, rd, oc);
    chk("R12", "vector not requesting silent", int'(a || e), 0);
  endtask

  task automatic testAsRelease();
    int rel = 0;
    openAddr(3'b111, 20'h04002);
    dsN = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mAck) break;
    end
    chk("R6", "ack before address release", int'(mAck), 1);
    asN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!(mAck || mOe)) break;
      @(negedge clk);
      rel++;
    end
    chk("R6", "release on address strobe within 4", int'(rel <= 4), 1);
    dsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testBurstDown();
    logic a, e; logic [7:0] rd; int oc;
    useDn = 1'b1;
    openAddr(3'b111, 20'h04020);
    for (int k = 0; k < 3; k++) begin
      handshake(8'h00, a, e, rd, oc);
      chk("R8", $sformatf("down burst k=%0d", k), int'(rd), 8'h80 + 32 - k);
    end
    closeAddr();
    useDn = 1'b0;
  endtask

  task automatic finishUp();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishUp();
  end

  initial begin
    for (int i = 0; i < 64; i++) memArr[i] = initMem(i);
    for (int i = 0; i < 16; i++) ioArr[i] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testMemRead();
    testMemWrite();
    testDsWithoutAs();
    testReserved();
    testOutside();
    testBurstUp();
    testReadOnly();
    testBurstEdge();
    testIo();
    testVector();
    testAsRelease();
    testBurstDown();
    finishUp();
  end

endmodule